// File: doc/BRIEF.md
# 8-bit ALU with selective status-flag update

This block is the arithmetic and logic stage of a small 8-bit processor core. An operation is handed in with a valid/ready handshake together with two byte operands, an immediate, an incoming carry and an operation code. The byte result and the six-bit status word come back from registers one cycle after acceptance. The status word is state kept inside the block. Each operation rewrites only the flags it owns, and every other flag keeps the value it had.

Two word operations add or subtract a small unsigned constant to or from a 16-bit register pair. They reuse the byte adder over two consecutive cycles: the low byte first, then the high byte with the carry or borrow from the low byte. While the second half runs, `op_ready` is low. An operation offered in that cycle is not taken, and the producer must hold it until `op_ready` is high again. The result side has no back-pressure: `out_valid` is a one-cycle pulse that marks new contents in `res_lo`, `res_hi` and `flags`.

Top module: `alu8_flags`

## Requirements
- R1: Status word bits are: [0] carry C, [1] zero Z, [2] negative N, [3] overflow V, [4] sign S, [5] half-carry H. Reset (rst_n low) clears all flags, `res_lo` and `res_hi`, drops `out_valid` and raises `op_ready`.
- R2: op_code 0 computes A+B and op_code 1 computes A+B+carry_in. Both update all six flags. C is the carry out of bit 7, H is the carry out of bit 3, and V is set when the signed sum does not fit in 8 bits. When `use_imm` is 1, `imm` replaces B for op_codes 0 to 6.
- R3: op_code 2 computes A−B and op_code 3 computes A−B−carry_in. Both update all six flags. C and H are the borrows out of bit 7 and bit 3, and V is set when the signed difference does not fit in 8 bits.
- R4: For op_code 3, Z becomes 0 when the result is nonzero. When the result is zero, Z keeps its previous value.
- R5: op_codes 4 (AND), 5 (OR) and 6 (XOR) update Z, N, V and S, with V forced to 0. C and H keep their values.
- R6: op_code 7 returns 0xFF−A, sets C to 1, clears V, updates Z, N and S, and keeps H.
- R7: op_code 8 returns 0x00−A and updates all six flags. C is 1 unless A is 0, and V is 1 only for A = 0x80.
- R8: op_code 9 returns A+1 and op_code 10 returns A−1. Both update Z, N, V and S and keep C and H. V is set only when the result is 0x80 (increment) or 0x7F (decrement).
- R9: op_code 11 returns 0xFF and leaves every flag unchanged. op_code 12 returns A AND NOT imm, and op_code 13 returns A OR imm. Both follow the flag rule of R5.
- R10: Whenever a flag update happens, S equals N XOR V of the new flags.
- R11: op_code 14 adds and op_code 15 subtracts imm[5:0] to or from the pair {opd_b, opd_a}. The result is on {res_hi, res_lo}. Z, C, N, V and S are updated as for a 16-bit operation, and H keeps its value.
- R12: A word operation keeps `op_ready` low in the cycle after it is accepted. An operation offered in that cycle is ignored, and `out_valid` rises two cycles after acceptance.
- R13: A byte operation raises `out_valid` for exactly one cycle, in the cycle after it is accepted, and puts 0 on `res_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Block can accept an operation |
| op_code | input | 4 | Operation select |
| use_imm | input | 1 | Use imm in place of opd_b for op_codes 0 to 6 |
| opd_a | input | 8 | First operand; low byte of the word pair |
| opd_b | input | 8 | Second operand; high byte of the word pair |
| imm | input | 8 | Immediate value; bits [5:0] are the word constant |
| carry_in | input | 1 | Carry or borrow into op_codes 1 and 3 |
| out_valid | output | 1 | One-cycle pulse: new result and flags |
| res_lo | output | 8 | Result byte, or low byte of the word result |
| res_hi | output | 8 | High byte of the word result, 0 for byte ops |
| flags | output | 6 | Status word {H,S,V,N,Z,C} |

## Verification
The bench targets the edges where one flag rule ends and another begins. It checks that carry and half-carry survive logic, increment and decrement operations; a design that rewrote them would lose the carry of a multi-byte chain. It checks that Z stays sticky across a zero subtract-with-carry, which a plain zero test would raise. It also drives the overflow corners 0x7F+1, 0x80−1 and negation of 0x80 and 0x00, and word operations whose carry or borrow crosses between the bytes, which catch a high byte computed without the low-byte carry. Finally, an operation is offered while a word operation is still busy, and the bench checks that it neither replaces the word result nor yields a second result pulse.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int NFLAG = 6;
  localparam int F_C = 0;
  localparam int F_Z = 1;
  localparam int F_N = 2;
  localparam int F_V = 3;
  localparam int F_S = 4;
  localparam int F_H = 5;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_COM  = 4'd7,
    OP_NEG  = 4'd8,
    OP_INC  = 4'd9,
    OP_DEC  = 4'd10,
    OP_SET  = 4'd11,
    OP_CLRB = 4'd12,
    OP_SETB = 4'd13,
    OP_ADDW = 4'd14,
    OP_SUBW = 4'd15
  } op_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         hc,
  output logic         ovf
);
  localparam int HB = W / 2;

  logic [W:0]  full;
  logic [HB:0] half;

  always_comb begin
    if (sub) begin
      full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
      half = {1'b0, a[HB-1:0]} - {1'b0, b[HB-1:0]} - {{HB{1'b0}}, cin};
    end else begin
      full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      half = {1'b0, a[HB-1:0]} + {1'b0, b[HB-1:0]} + {{HB{1'b0}}, cin};
    end
  end

  assign sum  = full[W-1:0];
  assign cout = full[W];
  assign hc   = half[HB];

  always_comb begin
    if (sub)
      ovf = (a[W-1] & ~b[W-1] & ~sum[W-1]) | (~a[W-1] & b[W-1] & sum[W-1]);
    else
      ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  op_t          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] k,
  output logic [W-1:0] res
);
  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_COM:  res = ~a;
      OP_CLRB: res = a & ~k;
      OP_SETB: res = a | k;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu8_flagrules.sv
module alu8_flagrules
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  op_t              op,
  input  logic [W-1:0]     res,
  input  logic             cout,
  input  logic             hc,
  input  logic             ovf,
  input  logic             z_old,
  input  logic             lo_zero,
  output logic [NFLAG-1:0] new_f,
  output logic [NFLAG-1:0] mask
);
  localparam logic [NFLAG-1:0] M_ALL   = '1;
  localparam logic [NFLAG-1:0] M_LOGIC = (1 << F_Z) | (1 << F_N) | (1 << F_V) | (1 << F_S);
  localparam logic [NFLAG-1:0] M_WORD  = M_LOGIC | (1 << F_C);

  logic zero, fn, fz, fc, fv, fh;

  assign zero = (res == '0);
  assign fn   = res[W-1];

  always_comb begin
    fz   = zero;
    fc   = cout;
    fv   = ovf;
    fh   = hc;
    mask = '0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_NEG: mask = M_ALL;
      OP_SBC: begin
        fz   = zero & z_old;
        mask = M_ALL;
      end
      OP_AND, OP_OR, OP_XOR, OP_CLRB, OP_SETB: begin
        fv   = 1'b0;
        mask = M_LOGIC;
      end
      OP_COM: begin
        fc   = 1'b1;
        fv   = 1'b0;
        mask = M_WORD;
      end
      OP_INC, OP_DEC: mask = M_LOGIC;
      OP_ADDW, OP_SUBW: begin
        fz   = zero & lo_zero;
        mask = M_WORD;
      end
      default: mask = '0;
    endcase
  end

  always_comb begin
    new_f      = '0;
    new_f[F_C] = fc;
    new_f[F_Z] = fz;
    new_f[F_N] = fn;
    new_f[F_V] = fv;
    new_f[F_S] = fn ^ fv;
    new_f[F_H] = fh;
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int W  = 8,
  parameter int KW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [3:0]       op_code,
  input  logic             use_imm,
  input  logic [W-1:0]     opd_a,
  input  logic [W-1:0]     opd_b,
  input  logic [W-1:0]     imm,
  input  logic             carry_in,
  output logic             out_valid,
  output logic [W-1:0]     res_lo,
  output logic [W-1:0]     res_hi,
  output logic [NFLAG-1:0] flags
);
  op_t              op_in, op_eff;
  logic             busy_q, fire, is_word_in, is_arith, flag_upd;
  logic [W-1:0]     bsel, kext, logic_res, byte_res, cur_res;
  logic [W-1:0]     core_a, core_b, core_sum;
  logic             core_cin, core_sub, core_cout, core_hc, core_ovf;
  logic [W-1:0]     lo_q, hi_q, res_lo_q, res_hi_q;
  logic             carry_q, sub_q, out_valid_q;
  logic [NFLAG-1:0] flags_q, new_f, mask;

  assign op_in      = op_t'(op_code);
  assign op_ready   = ~busy_q;
  assign fire       = op_valid & op_ready;
  assign is_word_in = (op_in == OP_ADDW) || (op_in == OP_SUBW);
  assign bsel       = use_imm ? imm : opd_b;
  assign kext       = {{(W-KW){1'b0}}, imm[KW-1:0]};
  assign op_eff     = busy_q ? (sub_q ? OP_SUBW : OP_ADDW) : op_in;

  // operand steering onto the shared adder
  always_comb begin
    core_a   = opd_a;
    core_b   = bsel;
    core_cin = 1'b0;
    core_sub = 1'b0;
    if (busy_q) begin
      core_a   = hi_q;
      core_b   = '0;
      core_cin = carry_q;
      core_sub = sub_q;
    end else begin
      case (op_in)
        OP_ADC:  core_cin = carry_in;
        OP_SUB:  core_sub = 1'b1;
        OP_SBC: begin
          core_sub = 1'b1;
          core_cin = carry_in;
        end
        OP_NEG: begin
          core_a   = '0;
          core_b   = opd_a;
          core_sub = 1'b1;
        end
        OP_INC:  core_b = {{(W-1){1'b0}}, 1'b1};
        OP_DEC: begin
          core_b   = {{(W-1){1'b0}}, 1'b1};
          core_sub = 1'b1;
        end
        OP_ADDW: core_b = kext;
        OP_SUBW: begin
          core_b   = kext;
          core_sub = 1'b1;
        end
        default: ;
      endcase
    end
  end

  alu8_addsub #(.W(W)) u_core (
    .a(core_a), .b(core_b), .cin(core_cin), .sub(core_sub),
    .sum(core_sum), .cout(core_cout), .hc(core_hc), .ovf(core_ovf)
  );

  alu8_logic #(.W(W)) u_logic (
    .op(op_in), .a(opd_a), .b(bsel), .k(imm), .res(logic_res)
  );

  always_comb begin
    case (op_in)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_INC, OP_DEC: is_arith = 1'b1;
      default: is_arith = 1'b0;
    endcase
  end

  assign byte_res = (op_in == OP_SET) ? {W{1'b1}} : (is_arith ? core_sum : logic_res);
  assign cur_res  = busy_q ? core_sum : byte_res;

  alu8_flagrules #(.W(W)) u_rules (
    .op(op_eff), .res(cur_res), .cout(core_cout), .hc(core_hc), .ovf(core_ovf),
    .z_old(flags_q[F_Z]), .lo_zero(lo_q == '0), .new_f(new_f), .mask(mask)
  );

  assign flag_upd = (fire & ~is_word_in) | busy_q;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)
        flags_q[g] <= 1'b0;
      else if (flag_upd && mask[g])
        flags_q[g] <= new_f[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      out_valid_q <= 1'b0;
      res_lo_q    <= '0;
      res_hi_q    <= '0;
      lo_q        <= '0;
      hi_q        <= '0;
      carry_q     <= 1'b0;
      sub_q       <= 1'b0;
    end else begin
      out_valid_q <= 1'b0;
      if (busy_q) begin
        res_lo_q    <= lo_q;
        res_hi_q    <= core_sum;
        out_valid_q <= 1'b1;
        busy_q      <= 1'b0;
      end else if (fire) begin
        if (is_word_in) begin
          lo_q    <= core_sum;
          carry_q <= core_cout;
          hi_q    <= opd_b;
          sub_q   <= (op_in == OP_SUBW);
          busy_q  <= 1'b1;
        end else begin
          res_lo_q    <= byte_res;
          res_hi_q    <= '0;
          out_valid_q <= 1'b1;
        end
      end
    end
  end

  assign out_valid = out_valid_q;
  assign res_lo    = res_lo_q;
  assign res_hi    = res_hi_q;
  assign flags     = flags_q;

  a_r9_set_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_in == OP_SET) |=> (flags_q == $past(flags_q)));

  a_r5_logic_keeps_ch: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (op_in == OP_AND || op_in == OP_OR || op_in == OP_XOR))
      |=> ($stable(flags_q[F_C]) && $stable(flags_q[F_H])));

  a_r8_incdec_keeps_c: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (op_in == OP_INC || op_in == OP_DEC)) |=> $stable(flags_q[F_C]));

  a_r4_sbc_z_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_in == OP_SBC) |=> !$rose(flags_q[F_Z]));

  a_r10_sign_rule: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[F_S] == (flags_q[F_N] ^ flags_q[F_V]));

  a_r12_word_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_word_in) |=> (!op_ready && !out_valid));

  a_r13_byte_result: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !is_word_in) |=> (out_valid && res_hi == '0));
endmodule

// File: tb/alu8_flags_bench.sv
module alu8_flags_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic       op_ready;
  logic [3:0] op_code = '0;
  logic       use_imm = 1'b0;
  logic [7:0] opd_a = '0, opd_b = '0, imm = '0;
  logic       carry_in = 1'b0;
  logic       out_valid;
  logic [7:0] res_lo, res_hi;
  logic [5:0] flags;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [5:0] ef = '0;  // expected {H,S,V,N,Z,C}

  always #5 clk = ~clk;

  alu8_flags u_alu8_flags (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .use_imm(use_imm), .opd_a(opd_a), .opd_b(opd_b),
    .imm(imm), .carry_in(carry_in), .out_valid(out_valid),
    .res_lo(res_lo), .res_hi(res_hi), .flags(flags)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic int sx(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  task automatic run_byte(input int oc, input int a, input int b, input int k,
                          input bit ui, input bit ci, input string tag);
    int bs, ia, ib, ic, r, sv;
    bit c, z, n, v, h, upd;
    bs = ui ? k : b;
    c = ef[0]; z = ef[1]; v = ef[3]; h = ef[5]; upd = 1;
    case (oc)
      0, 1: begin
        ic = (oc == 1) ? ci : 0;
        r = a + bs + ic;
        c = r > 255; h = ((a & 15) + (bs & 15) + ic) > 15;
        sv = sx(a) + sx(bs) + ic; v = (sv > 127) || (sv < -128);
        z = (r & 255) == 0;
      end
      2, 3, 8: begin
        ia = (oc == 8) ? 0 : a; ib = (oc == 8) ? a : bs;
        ic = (oc == 3) ? ci : 0;
        r = ia - ib - ic;
        c = r < 0; h = ((ia & 15) - (ib & 15) - ic) < 0;
        sv = sx(ia) - sx(ib) - ic; v = (sv > 127) || (sv < -128);
        z = ((r & 255) == 0) && ((oc != 3) || ef[1]);
      end
      4: begin r = a & bs; v = 0; z = (r & 255) == 0; end
      5: begin r = a | bs; v = 0; z = (r & 255) == 0; end
      6: begin r = a ^ bs; v = 0; z = (r & 255) == 0; end
      12: begin r = a & (255 - k); v = 0; z = (r & 255) == 0; end
      13: begin r = a | k; v = 0; z = (r & 255) == 0; end
      7: begin r = 255 - a; c = 1; v = 0; z = (r & 255) == 0; end
      9: begin r = a + 1; v = (a == 127); z = (r & 255) == 0; end
      10: begin r = a - 1; v = (a == 128); z = (r & 255) == 0; end
      default: begin r = 255; upd = 0; end
    endcase
    r = r & 255;
    if (upd) begin
      n = r[7];
      ef = {h, n ^ v, v, n, z, c};
    end
    @(negedge clk);
    op_code = oc[3:0]; opd_a = a[7:0]; opd_b = b[7:0]; imm = k[7:0];
    use_imm = ui; carry_in = ci; op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " out_valid"}, out_valid, 1);
    chk({tag, " res_lo"}, res_lo, r);
    chk({tag, " res_hi R13"}, res_hi, 0);
    chk({tag, " flags"}, flags, ef);
    op_valid = 1'b0;
    @(negedge clk);
    chk({tag, " pulse R13"}, out_valid, 0);
  endtask

  task automatic run_word(input bit is_sub, input int lo, input int hi, input int k,
                          input string tag);
    int p, r;
    bit c, v, n;
    p = hi * 256 + lo;
    r = is_sub ? p - k : p + k;
    c = is_sub ? (r < 0) : (r > 65535);
    r = r & 65535;
    n = r[15];
    v = is_sub ? (p[15] & ~r[15]) : (~p[15] & r[15]);
    ef = {ef[5], n ^ v, v, n, r == 0, c};
    @(negedge clk);
    op_code = is_sub ? 4'd15 : 4'd14; opd_a = lo[7:0]; opd_b = hi[7:0];
    imm = k[7:0]; use_imm = 1'b0; op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " stall ready R12"}, op_ready, 0);
    chk({tag, " stall valid R12"}, out_valid, 0);
    // offer a set-all op during the stall: must be ignored (R12)
    op_code = 4'd11; opd_a = 8'h00;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    chk({tag, " out_valid R12"}, out_valid, 1);
    chk({tag, " res_lo R11"}, res_lo, r & 255);
    chk({tag, " res_hi R11"}, res_hi, r >> 8);
    chk({tag, " flags R11"}, flags, ef);
    @(negedge clk);
    chk({tag, " no extra R12"}, out_valid, 0);
    chk({tag, " res kept R12"}, res_lo, r & 255);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("reset flags R1", flags, 0);
    chk("reset valid R1", out_valid, 0);
    chk("reset ready R1", op_ready, 1);
    chk("reset res R1", {res_hi, res_lo}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_add();
    run_byte(0, 8'h7F, 8'h01, 0, 0, 0, "add ovf R2");
    run_byte(1, 8'hFF, 8'h00, 0, 0, 1, "adc wrap R2");
    run_byte(0, 8'h12, 8'h00, 8'h34, 1, 0, "add imm R2");
    run_byte(0, 8'h80, 8'h80, 0, 0, 0, "add neg ovf R10");
  endtask

  task automatic t_sub();
    run_byte(2, 8'h00, 8'h00, 8'h01, 1, 0, "sub imm borrow R3");
    run_byte(2, 8'h80, 8'h01, 0, 0, 0, "sub ovf R3");
    run_byte(2, 8'h10, 8'h10, 0, 0, 0, "sub zero R3");
    run_byte(3, 8'h00, 8'h00, 0, 0, 0, "sbc zero keeps Z R4");
    run_byte(3, 8'h05, 8'h03, 0, 0, 1, "sbc nonzero R4");
    run_byte(3, 8'h00, 8'h00, 0, 0, 0, "sbc zero no rise R4");
  endtask

  task automatic t_logic();
    run_byte(0, 8'hFF, 8'h11, 0, 0, 0, "prime C H R2");
    run_byte(4, 8'hF0, 8'h0F, 0, 0, 0, "and zero R5");
    run_byte(5, 8'h80, 8'h01, 0, 0, 0, "or R5");
    run_byte(6, 8'hAA, 8'h00, 8'hFF, 1, 0, "xor imm R5");
    run_byte(12, 8'hFF, 8'h00, 8'h0F, 0, 0, "clrb R9");
    run_byte(13, 8'h00, 8'h00, 8'h81, 0, 0, "setb R9");
  endtask

  task automatic t_unary();
    run_byte(7, 8'h55, 0, 0, 0, 0, "com R6");
    run_byte(7, 8'hFF, 0, 0, 0, 0, "com zero R6");
    run_byte(8, 8'h80, 0, 0, 0, 0, "neg 80 R7");
    run_byte(8, 8'h00, 0, 0, 0, 0, "neg 00 R7");
    run_byte(8, 8'h01, 0, 0, 0, 0, "neg 01 R7");
    run_byte(0, 8'hFF, 8'h01, 0, 0, 0, "prime C R2");
    run_byte(9, 8'h7F, 0, 0, 0, 0, "inc ovf R8");
    run_byte(10, 8'h80, 0, 0, 0, 0, "dec ovf R8");
    run_byte(10, 8'h00, 0, 0, 0, 0, "dec wrap R8");
    run_byte(11, 8'h3C, 0, 0, 0, 0, "set all R9");
  endtask

  task automatic t_word();
    run_word(0, 8'hFF, 8'h00, 1, "addw carry");
    run_word(0, 8'hFF, 8'hFF, 1, "addw wrap");
    run_word(1, 8'h00, 8'h00, 1, "subw borrow");
    run_word(1, 8'h00, 8'h80, 63, "subw ovf");
    run_word(0, 8'h10, 8'h7F, 63, "addw none");
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_unary();
    t_word();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule